// File: doc/BRIEF.md
# Hexagonal Window Fetch and Assembly

This block walks an image held in a synchronous on-chip RAM and builds, column by column, a seven-cell hexagonal neighbourhood for a downstream evaluator. The image sits in the RAM in row-major order (pixel at row `y`, column `x` lives at address `y*IMG_W + x`). Alternate rows are treated as shifted by half a pixel. Rows with odd index sit half a pixel to the right of rows with even index. The window therefore has two cells in the row above, three in the centre row and two in the row below.

The scan covers the image in bands of three consecutive rows. For each column step it issues three read addresses on three consecutive clocks: upper row, centre row, lower row. A selection counter steers each returned pixel into one of three staging registers. Once all three have arrived, the staging column moves into the window in one step and the older columns shift along. Two column pointers, one for even rows and one for odd rows, produce the half-pixel alignment. When a band's centre row is even, the centre row is read one column ahead of the outer rows. A one-cycle strobe marks each complete window and comes with the RAM address of its centre pixel.

Top module: `hex_window_fetch`

## Requirements
- R1: While `rstN` is low, every window cell reads 0, `winValid` is 0, `memRdEn` is 1 and `memAddr` is 0. The scan restarts from address 0 whenever reset is applied, including in the middle of a frame.
- R2: A column step of band `b` with step index `k` issues three addresses on three consecutive clocks, in this order: upper `b*W + k`, centre `(b+1)*W + k + e`, lower `(b+2)*W + k`. Here `e` is 1 when the centre row `b+1` is even and 0 otherwise. For an 8x8 image the first six addresses are 0, 8, 16, 1, 9, 17.
- R3: In a band whose centre row is even, the centre-row address leads the outer-row addresses by exactly one column (`e = 1` in R2). In bands with an odd centre row all three addresses share one column.
- R4: A band has `W` column steps when its centre row is odd and `W-1` when it is even. After the last step the scan moves down one row. After the band whose centre row is `H-2`, `memRdEn` falls to 0 and stays there.
- R5: The RAM returns data one clock after the address. Three clocks after the lower-row address of a step is issued, the cells hold the following pixels: `upNew`, `midNew` and `lowNew` hold that step's upper, centre and lower pixels. `upOld`, `midCtr` and `lowOld` hold the previous step's pixels. `midOld` holds the centre pixel from two steps back.
- R6: `winValid` is a one-cycle pulse in the cycle the window changes, and only from the third step of a band onward (`k >= 2`). It is never asserted for a window that spans two bands.
- R7: When `winValid` is 1, `winCenter` equals the RAM address of the pixel in `midCtr`.
- R8: Window cells change only on a column step (once every three clocks). They are stable in the two cycles between steps and after the frame ends.
- R9: A full frame produces `W-2` valid windows for each band with an odd centre row and `W-3` for each band with an even centre row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdData | input | PIX_W | RAM read data, one clock after the address |
| memAddr | output | ADDR_W | RAM read address |
| memRdEn | output | 1 | High while the scan is issuing reads |
| upNew | output | PIX_W | Upper row, newest column |
| upOld | output | PIX_W | Upper row, previous column |
| midNew | output | PIX_W | Centre row, newest column |
| midCtr | output | PIX_W | Centre pixel of the window |
| midOld | output | PIX_W | Centre row, oldest column |
| lowNew | output | PIX_W | Lower row, newest column |
| lowOld | output | PIX_W | Lower row, previous column |
| winValid | output | 1 | One-cycle strobe: the window is complete |
| winCenter | output | ADDR_W | Address of the centre pixel, valid with winValid |

## Verification
Cycle 0 is the first clock after reset is released, and global step `s` puts its three addresses out in cycles `3s`, `3s+1` and `3s+2`. The RAM model answers one clock later, the staging register captures one clock after that, and the window shift adds one more clock. The cells, `winValid` and `winCenter` for step `s` are therefore due in cycle `3s+5`, and the bench compares them against values it computes for exactly that cycle. In the two cycles that follow, it expects the cells to be unchanged and the strobe to be low. The bench samples on the falling clock edge and counts cycles from the release of reset, so each comparison lands in a known cycle.

// File: rtl/hexwin_pkg.sv
`timescale 1ns/1ps
package hexwin_pkg;
  // strobes from the scan controller to the window datapath
  typedef struct packed {
    logic       load;   // a returned pixel is present on rdData this cycle
    logic [1:0] sel;    // staging register that takes it (0 upper, 1 centre, 2 lower)
    logic       shift;  // staging column moves into the window this cycle
  } hexFetchCtl_t;
endpackage

// File: rtl/hexwin_ctrl.sv
`timescale 1ns/1ps
module hexwin_ctrl
  import hexwin_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 64,
  localparam int ADDR_W = $clog2(IMG_W * IMG_H),
  localparam int COL_W  = $clog2(IMG_W + 1),
  localparam int BAND_W = $clog2(IMG_H)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output hexFetchCtl_t      ctl,
  output logic              winValid,
  output logic [ADDR_W-1:0] winCenter
);
  logic              active;
  logic [1:0]        phase;
  logic [COL_W-1:0]  stepK;
  logic [BAND_W-1:0] band;
  logic [ADDR_W-1:0] bandBase;
  logic [COL_W-1:0]  evenColPtr;
  logic [COL_W-1:0]  oddColPtr;

  logic              centerEven;
  logic [COL_W-1:0]  midCol;
  logic [COL_W-1:0]  outerCol;
  logic [ADDR_W-1:0] rowOffset;
  logic              lastStep;
  logic              lastBand;

  logic              s1Load, s1Last, s1Full;
  logic [1:0]        s1Sel;
  logic [ADDR_W-1:0] s1Center;
  logic              s2Shift, s2Full;
  logic [ADDR_W-1:0] s2Center;

  // centre row is band+1, so it is even exactly when band is odd
  assign centerEven = band[0];
  assign midCol     = centerEven ? evenColPtr : oddColPtr;
  assign outerCol   = centerEven ? oddColPtr  : evenColPtr;
  assign lastStep   = (stepK == (centerEven ? COL_W'(IMG_W - 2) : COL_W'(IMG_W - 1)));
  assign lastBand   = (band == BAND_W'(IMG_H - 3));

  always_comb begin
    unique case (phase)
      2'd0:    rowOffset = '0;
      2'd1:    rowOffset = ADDR_W'(IMG_W);
      default: rowOffset = ADDR_W'(2 * IMG_W);
    endcase
  end

  assign memAddr = bandBase + rowOffset + ADDR_W'((phase == 2'd1) ? midCol : outerCol);
  assign memRdEn = active;

  // scan state: selection counter, column step, band, two row-parity pointers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active     <= 1'b1;
      phase      <= 2'd0;
      stepK      <= '0;
      band       <= '0;
      bandBase   <= '0;
      evenColPtr <= '0;
      oddColPtr  <= '0;
    end else if (active) begin
      if (phase != 2'd2) begin
        phase <= phase + 2'd1;
      end else begin
        phase <= 2'd0;
        if (lastStep) begin
          if (lastBand) begin
            active <= 1'b0;
          end else begin
            band       <= band + BAND_W'(1);
            bandBase   <= bandBase + ADDR_W'(IMG_W);
            stepK      <= '0;
            // next band centre is even when the current band index is even
            evenColPtr <= centerEven ? COL_W'(0) : COL_W'(1);
            oddColPtr  <= '0;
          end
        end else begin
          stepK      <= stepK + COL_W'(1);
          evenColPtr <= evenColPtr + COL_W'(1);
          oddColPtr  <= oddColPtr + COL_W'(1);
        end
      end
    end
  end

  // stage 1 lines up with the RAM output, stage 2 with the staging column
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Load    <= 1'b0;
      s1Sel     <= 2'd0;
      s1Last    <= 1'b0;
      s1Full    <= 1'b0;
      s1Center  <= '0;
      s2Shift   <= 1'b0;
      s2Full    <= 1'b0;
      s2Center  <= '0;
      winValid  <= 1'b0;
      winCenter <= '0;
    end else begin
      s1Load   <= active;
      s1Sel    <= phase;
      s1Last   <= active && (phase == 2'd2);
      s1Full   <= (stepK >= COL_W'(2));
      s1Center <= bandBase + ADDR_W'(IMG_W) + ADDR_W'(midCol) - ADDR_W'(1);
      s2Shift  <= s1Last;
      s2Full   <= s1Full;
      s2Center <= s1Center;
      winValid <= s2Shift && s2Full;
      if (s2Shift && s2Full) winCenter <= s2Center;
    end
  end

  assign ctl.load  = s1Load;
  assign ctl.sel   = s1Sel;
  assign ctl.shift = s2Shift;

  // R2: centre-row address sits one row below the upper one, plus the lead (R3)
  a_r2_mid_stride: assert property (@(posedge clk) disable iff (!rstN)
    (active && phase == 2'd1) |-> memAddr == $past(memAddr) + ADDR_W'(IMG_W) + ADDR_W'(centerEven));

  // R3: lower row returns to the outer column
  a_r3_outer_stride: assert property (@(posedge clk) disable iff (!rstN)
    (active && phase == 2'd2) |-> memAddr == $past(memAddr) + ADDR_W'(IMG_W) - ADDR_W'(centerEven));

  // R4: once the scan stops it stays stopped
  a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    !memRdEn |=> !memRdEn);

  // R6: the strobe lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    winValid |=> !winValid);

  // R6: a strobe only follows a column transfer
  a_r6_after_shift: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> $past(ctl.shift));
endmodule

// File: rtl/hexwin_datapath.sv
`timescale 1ns/1ps
module hexwin_datapath
  import hexwin_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  hexFetchCtl_t     ctl,
  input  logic [PIX_W-1:0] rdData,
  output logic [PIX_W-1:0] upNew,
  output logic [PIX_W-1:0] upOld,
  output logic [PIX_W-1:0] midNew,
  output logic [PIX_W-1:0] midCtr,
  output logic [PIX_W-1:0] midOld,
  output logic [PIX_W-1:0] lowNew,
  output logic [PIX_W-1:0] lowOld
);
  localparam int STAGES = 3;

  logic [PIX_W-1:0] stage [STAGES];

  // 1:3 demultiplexer into the staging column
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[g] <= '0;
      end else if (ctl.load && ctl.sel == 2'(g)) begin
        stage[g] <= rdData;
      end
    end
  end

  // window: the staging column enters as the newest column, older ones slide along
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upNew  <= '0;
      upOld  <= '0;
      midNew <= '0;
      midCtr <= '0;
      midOld <= '0;
      lowNew <= '0;
      lowOld <= '0;
    end else if (ctl.shift) begin
      upOld  <= upNew;
      midOld <= midCtr;
      midCtr <= midNew;
      lowOld <= lowNew;
      upNew  <= stage[0];
      midNew <= stage[1];
      lowNew <= stage[2];
    end
  end

  // R2: the selection counter walks upper then centre
  a_r2_sel_order: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.sel == 2'd0) |=> (ctl.load && ctl.sel == 2'd1));

  // R5: a transfer always follows the lower-row capture
  a_r5_shift_after_lower: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift |-> $past(ctl.load && ctl.sel == 2'd2));

  // R8: the centre cell holds between transfers
  a_r8_center_stable: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.shift) |-> $stable(midCtr));
endmodule

// File: rtl/hex_window_fetch.sv
`timescale 1ns/1ps
module hex_window_fetch
  import hexwin_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 64,
  parameter int PIX_W = 8,
  localparam int ADDR_W = $clog2(IMG_W * IMG_H)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PIX_W-1:0]  rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic [PIX_W-1:0]  upNew,
  output logic [PIX_W-1:0]  upOld,
  output logic [PIX_W-1:0]  midNew,
  output logic [PIX_W-1:0]  midCtr,
  output logic [PIX_W-1:0]  midOld,
  output logic [PIX_W-1:0]  lowNew,
  output logic [PIX_W-1:0]  lowOld,
  output logic              winValid,
  output logic [ADDR_W-1:0] winCenter
);
  hexFetchCtl_t ctl;

  hexwin_ctrl #(
    .IMG_W(IMG_W),
    .IMG_H(IMG_H)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .memAddr  (memAddr),
    .memRdEn  (memRdEn),
    .ctl      (ctl),
    .winValid (winValid),
    .winCenter(winCenter)
  );

  hexwin_datapath #(
    .PIX_W(PIX_W)
  ) i_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .rdData(rdData),
    .upNew (upNew),
    .upOld (upOld),
    .midNew(midNew),
    .midCtr(midCtr),
    .midOld(midOld),
    .lowNew(lowNew),
    .lowOld(lowOld)
  );
endmodule

// File: tb/test_hex_window_fetch.sv
`timescale 1ns/1ps
module test_hex_window_fetch;
  localparam int W  = 8;
  localparam int H  = 8;
  localparam int AW = $clog2(W * H);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    rdData = '0;
  logic [AW-1:0] memAddr, winCenter;
  logic          memRdEn, winValid;
  logic [7:0]    upNew, upOld, midNew, midCtr, midOld, lowNew, lowOld;

  int checks = 0;
  int errors = 0;
  int nSteps = 0;
  int stepBand  [0:255];
  int stepOuter [0:255];
  int stepMid   [0:255];
  int stepFull  [0:255];

  always #2.5 clk = ~clk;

  hex_window_fetch #(.IMG_W(W), .IMG_H(H), .PIX_W(8)) i_hex_window_fetch (
    .clk(clk), .rstN(rstN), .rdData(rdData), .memAddr(memAddr), .memRdEn(memRdEn),
    .upNew(upNew), .upOld(upOld), .midNew(midNew), .midCtr(midCtr), .midOld(midOld),
    .lowNew(lowNew), .lowOld(lowOld), .winValid(winValid), .winCenter(winCenter)
  );

  function automatic logic [7:0] pix(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // RAM model: data for the presented address one clock later
  always @(posedge clk) rdData <= pix(int'(memAddr));

  task automatic chk(string tag, string what, int n, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d got %0d expected %0d", tag, what, n, got, exp);
    end
  endtask

  // expected step list built from R2, R3 and R4
  task automatic buildModel();
    nSteps = 0;
    for (int b = 0; b <= H - 3; b++) begin
      int e = ((b + 1) % 2 == 0) ? 1 : 0;
      for (int k = 0; k < W - e; k++) begin
        stepBand[nSteps]  = b;
        stepOuter[nSteps] = k;
        stepMid[nSteps]   = k + e;
        stepFull[nSteps]  = (k >= 2) ? 1 : 0;
        nSteps++;
      end
    end
  endtask

  function automatic int expAddr(int n);
    int s = n / 3;
    int p = n % 3;
    int b = stepBand[s];
    if (p == 1) return (b + 1) * W + stepMid[s];
    return (b + p) * W + stepOuter[s];
  endfunction

  function automatic int cellAt(int s, int row);
    if (s < 0) return 0;
    if (row == 1) return int'(pix((stepBand[s] + 1) * W + stepMid[s]));
    return int'(pix((stepBand[s] + row) * W + stepOuter[s]));
  endfunction

  task automatic checkResetState(string tag);
    chk(tag, "memAddr", -1, int'(memAddr), 0);
    chk(tag, "memRdEn", -1, int'(memRdEn), 1);
    chk(tag, "winValid", -1, int'(winValid), 0);
    chk(tag, "midCtr", -1, int'(midCtr), 0);
    chk(tag, "upNew", -1, int'(upNew), 0);
    chk(tag, "lowOld", -1, int'(lowOld), 0);
    chk(tag, "midOld", -1, int'(midOld), 0);
  endtask

  // reset applied and released on falling edges; returns in cycle 0
  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    checkResetState("R1");
    rstN = 1'b1;
  endtask

  task automatic testAddressOrder();
    doReset();
    for (int n = 0; n < 3 * nSteps; n++) begin
      int s = n / 3;
      string tag = ((n % 3 == 1) && (stepMid[s] != stepOuter[s])) ? "R3" : "R2";
      chk("R2", "memRdEn", n, int'(memRdEn), 1);
      chk(tag, "memAddr", n, int'(memAddr), expAddr(n));
      @(negedge clk);
    end
    for (int n = 0; n < 6; n++) begin
      chk("R4", "memRdEn after frame", 3 * nSteps + n, int'(memRdEn), 0);
      @(negedge clk);
    end
  endtask

  task automatic testWindow();
    doReset();
    for (int n = 0; n < 3 * nSteps + 8; n++) begin
      int j = (n >= 5) ? (n - 5) / 3 : -1;
      bit onStep = (n >= 5) && ((n - 5) % 3 == 0) && (j < nSteps);
      string tag = onStep ? "R5" : "R8";
      if (j >= nSteps) j = nSteps - 1;
      chk(tag, "upNew",  n, int'(upNew),  cellAt(j, 0));
      chk(tag, "midNew", n, int'(midNew), cellAt(j, 1));
      chk(tag, "lowNew", n, int'(lowNew), cellAt(j, 2));
      chk(tag, "upOld",  n, int'(upOld),  cellAt(j - 1, 0));
      chk(tag, "midCtr", n, int'(midCtr), cellAt(j - 1, 1));
      chk(tag, "lowOld", n, int'(lowOld), cellAt(j - 1, 2));
      chk(tag, "midOld", n, int'(midOld), cellAt(j - 2, 1));
      chk("R6", "winValid", n, int'(winValid), (onStep && stepFull[j] == 1) ? 1 : 0);
      if (onStep && stepFull[j] == 1)
        chk("R7", "winCenter", n, int'(winCenter), (stepBand[j] + 1) * W + stepMid[j] - 1);
      @(negedge clk);
    end
  endtask

  task automatic testWindowCount();
    int got = 0;
    int exp = 0;
    for (int b = 0; b <= H - 3; b++) exp += (((b + 1) % 2) == 1) ? W - 2 : W - 3;
    doReset();
    for (int n = 0; n < 3 * nSteps + 10; n++) begin
      if (winValid) got++;
      @(negedge clk);
    end
    chk("R9", "valid window count", 3 * nSteps + 10, got, exp);
  endtask

  task automatic testMidFrameReset();
    doReset();
    repeat (20) @(negedge clk);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkResetState("R1");
    rstN = 1'b1;
    chk("R1", "restart address", 0, int'(memAddr), 0);
    @(negedge clk);
    chk("R1", "second address", 1, int'(memAddr), W);
  endtask

  initial begin
    buildModel();
    testAddressOrder();
    testWindow();
    testWindowCount();
    testMidFrameReset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule